// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache between a processor port that reads and writes single 32-bit words and a memory port that moves whole 128-bit lines. Every cached line holds four words and has a tag, a valid flag and a dirty flag. A hit answers one cycle after the request and causes no memory traffic. A miss starts a small state machine. If the victim line is dirty, the machine first writes it back to memory. It then fetches the requested line and replays the request, which now hits.

Writes use write-back with write-allocate. A write that hits changes only the cached word and marks the line dirty. A write that misses first brings the whole line in and then stores the word. A separate snoop input carries addresses of incoming I/O data. When such an address falls in a cached line, that line is dropped at once, and any dirty contents are discarded. The snoop input has priority over a processor request presented in the same cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: Address bits [3:2] select the word within a line, the next INDEX_W bits (default 12, bits [15:4]) select the line, and the remaining upper bits (default 16, bits [31:16]) form the tag. Bits [1:0] are ignored.
- R2: A request that finds its line valid with an equal tag raises cpu_ready for exactly one cycle, one cycle after the request. No memory request occurs, and a read returns the addressed word.
- R3: A read miss fetches the full line with one memory read. mem_addr carries the line address with bits [3:0] zero, and word w of the line travels in mem_rdata[32w+31:32w]. The requested word is then returned.
- R4: A write hit replaces only the addressed word in the cache, marks the line dirty and issues no memory write.
- R5: A write miss first fills the line from memory and then writes the word. The other three words keep their memory values.
- R6: A miss whose victim line is valid and dirty first writes the old line back (mem_we high, old tag and index in mem_addr, line in mem_wdata) and only then issues the fill read.
- R7: A miss whose victim line is clean or invalid issues no write-back.
- R8: While inv_valid is high, an inv_addr that matches a valid cached line clears that line's valid flag without a write-back. A later access to that line misses and sees the memory contents.
- R9: An inv_addr whose tag does not match the cached line leaves that line in place, so a later access still hits.
- R10: In a cycle with inv_valid high, a processor request is not accepted; it is served once inv_valid is low.
- R11: After reset all lines are invalid, and cpu_ready and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 32 | Line address |
| mem_wdata | output | 128 | Line being written back |
| mem_ready | input | 1 | Memory completion pulse |
| mem_rdata | input | 128 | Fill line, valid with mem_ready |
| inv_valid | input | 1 | I/O input address valid |
| inv_addr | input | 32 | I/O input address to invalidate |

## Verification
The assertions assume that the processor keeps cpu_req, cpu_we, cpu_addr and cpu_wdata steady from the request until cpu_ready, and lowers cpu_req in the cycle cpu_ready is seen. They also assume that memory raises mem_ready for a single cycle only while mem_req is high. The bench's memory responder and its access task follow both rules. Snoop pulses are issued either between processor requests or, for the priority check, with a request already pending, so no request is ever withdrawn before it completes.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int INDEX_W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_req,
  input  logic         cpu_we,
  input  logic [31:0]  cpu_addr,
  input  logic [31:0]  cpu_wdata,
  output logic         cpu_ready,
  output logic [31:0]  cpu_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [127:0] mem_wdata,
  input  logic         mem_ready,
  input  logic [127:0] mem_rdata,
  input  logic         inv_valid,
  input  logic [31:0]  inv_addr
);
  localparam int TAG_W = 28 - INDEX_W;
  localparam int LINES = 1 << INDEX_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [LINES-1:0] vld, dty;
  logic [TAG_W-1:0] tags  [LINES];
  logic [127:0]     lines [LINES];

  wire [1:0]         woff = cpu_addr[3:2];
  wire [INDEX_W-1:0] idx  = cpu_addr[4 +: INDEX_W];
  wire [TAG_W-1:0]   tg   = cpu_addr[31 -: TAG_W];
  wire               hit  = vld[idx] && (tags[idx] == tg);

  wire [INDEX_W-1:0] iidx = inv_addr[4 +: INDEX_W];
  wire               ihit = vld[iidx] && (tags[iidx] == inv_addr[31 -: TAG_W]);

  wire take = (st == S_IDLE) && cpu_req && !cpu_ready && !inv_valid;

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tags[idx], idx, 4'b0} : {tg, idx, 4'b0};
  assign mem_wdata = lines[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld       <= '0;
      dty       <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      if (inv_valid && ihit) vld[iidx] <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (hit) begin
            cpu_ready <= 1'b1;
            if (cpu_we) begin
              lines[idx][woff*32 +: 32] <= cpu_wdata;
              dty[idx] <= 1'b1;
            end else begin
              cpu_rdata <= lines[idx][woff*32 +: 32];
            end
          end else begin
            st <= (vld[idx] && dty[idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ready) st <= S_FILL;
        S_FILL: if (mem_ready) begin
          lines[idx] <= mem_rdata;
          tags[idx]  <= tg;
          vld[idx]   <= 1'b1;
          dty[idx]   <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  p_ready_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));
  p_fill_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> !mem_req);
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && ihit && st == S_IDLE) |=> !vld[$past(iidx)]);
  p_inv_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && st == S_IDLE) |=> !cpu_ready);
  p_addr_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[3:0] == 4'b0));
endmodule

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
  localparam int CLK_P = 10;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [127:0] mem_wdata;
  logic mem_ready = 0;
  logic [127:0] mem_rdata = 0;
  logic inv_valid = 0;
  logic [31:0] inv_addr = 0;

  always #(CLK_P/2) clk = ~clk;

  dm_wb_cache #(.INDEX_W(IW)) u0 (.*);

  logic [31:0] mem [128];
  int n_wb = 0, n_fill = 0;
  int vectors = 0, errors = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_ready) begin
      mem_ready <= 1'b1;
      if (mem_we) begin
        n_wb <= n_wb + 1;
        for (int w = 0; w < 4; w++) mem[{mem_addr[8:4], w[1:0]}] <= mem_wdata[32*w +: 32];
      end else begin
        n_fill <= n_fill + 1;
        for (int w = 0; w < 4; w++) mem_rdata[32*w +: 32] <= mem[{mem_addr[8:4], w[1:0]}];
      end
    end else mem_ready <= 1'b0;
  end

  // bench's own cache model: 4 lines, 3-bit tag (addresses below 0x200)
  logic       m_v [4], m_d [4];
  logic [2:0] m_t [4];
  logic [31:0] m_dat [4][4];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic we, logic [31:0] addr, logic [31:0] wd);
    int cyc = 0, wb0, fi0;
    logic [1:0] ix = addr[5:4], w = addr[3:2];
    logic [2:0] tg = addr[8:6];
    logic hit, dirty_evict;
    logic [2:0] old_t;
    logic [31:0] old_line [4];
    hit = m_v[ix] && m_t[ix] == tg;
    dirty_evict = !hit && m_v[ix] && m_d[ix];
    old_t = m_t[ix];
    for (int k = 0; k < 4; k++) old_line[k] = m_dat[ix][k];
    wb0 = n_wb; fi0 = n_fill;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    do begin
      @(negedge clk); cyc++;
    end while (!cpu_ready && cyc < 100);
    cpu_req = 0;
    check("R2 completion", {31'd0, cpu_ready}, 32'd1);
    if (hit) begin
      check("R2 hit latency", cyc, 1);
    end else begin
      m_v[ix] = 1; m_d[ix] = 0; m_t[ix] = tg;
      for (int k = 0; k < 4; k++) m_dat[ix][k] = mem[{tg, ix, k[1:0]}];
    end
    check(dirty_evict ? "R6 write-back count" : "R7 no write-back", n_wb - wb0, dirty_evict ? 1 : 0);
    check(we ? "R5 fill count" : "R3 fill count", n_fill - fi0, hit ? 0 : 1);
    if (dirty_evict)
      for (int k = 0; k < 4; k++) check("R6 line written back", mem[{old_t, ix, k[1:0]}], old_line[k]);
    if (we) begin
      m_dat[ix][w] = wd; m_d[ix] = 1;
    end else begin
      check(hit ? "R2 read data" : "R3 miss read data", cpu_rdata, m_dat[ix][w]);
    end
  endtask

  task automatic snoop(logic [31:0] addr);
    logic [1:0] ix = addr[5:4];
    int wb0 = n_wb;
    @(negedge clk);
    inv_valid = 1; inv_addr = addr;
    @(negedge clk);
    inv_valid = 0;
    if (m_v[ix] && m_t[ix] == addr[8:6]) m_v[ix] = 0;
    repeat (3) @(negedge clk);
    check("R8 no write-back on invalidate", n_wb - wb0, 0);
  endtask

  initial begin
    int cyc;
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 128; i++) mem[i] = 32'hA5000000 ^ (i * 32'h00010203);
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = 0; end
    repeat (3) @(negedge clk);
    check("R11 ready low in reset", {31'd0, cpu_ready}, 0);
    check("R11 mem_req low in reset", {31'd0, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // R11/R3: first read must miss
    access(0, 32'h0000_0014, 0);
    // R1: byte offset bits ignored, word select by [3:2]
    access(0, 32'h0000_0017, 0);
    access(0, 32'h0000_001C, 0);
    // R4: write hit, no memory write
    access(1, 32'h0000_0018, 32'hDEAD_0001);
    check("R4 memory untouched", mem[{3'd0, 2'd1, 2'd2}], 32'hA5000000 ^ (6 * 32'h00010203));
    access(0, 32'h0000_0018, 0);
    access(0, 32'h0000_0010, 0);
    // R6: dirty eviction by conflicting tag
    access(0, 32'h0000_0054, 0);
    check("R6 written word in memory", mem[{3'd0, 2'd1, 2'd2}], 32'hDEAD_0001);
    // R5: write miss allocates
    access(1, 32'h0000_0128, 32'h1234_5678);
    access(0, 32'h0000_0124, 0);
    access(0, 32'h0000_0128, 0);
    // R9: non-matching snoop keeps line
    snoop(32'h0000_0028);
    access(0, 32'h0000_012C, 0);
    // R8: matching snoop drops dirty data
    snoop(32'h0000_0120);
    access(0, 32'h0000_0128, 0);
    // R10: snoop in same cycle as a request delays it
    access(0, 32'h0000_0030, 0);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'h0000_0034; inv_valid = 1; inv_addr = 32'h0000_0100;
    @(negedge clk);
    inv_valid = 0;
    check("R10 no accept under snoop", {31'd0, cpu_ready}, 0);
    cyc = 0;
    while (!cpu_ready && cyc < 20) begin @(negedge clk); cyc++; end
    cpu_req = 0;
    check("R10 served after snoop", cyc, 1);
    check("R10 data", cpu_rdata, m_dat[3][1]);
    // sweep
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[15:13] == 3'd0) snoop({23'd0, lf[8:0]});
      else access(lf[12], {23'd0, lf[8:2], 2'b00}, {lf, ~lf});
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule